// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write and Completion-Polling Sequencer

This block sits between a synchronous host and an asynchronous, byte-wide EEPROM. The host hands it one request at a time over a valid/ready handshake: either a byte write or a plain read. The sequencer produces the chip-enable, output-enable and write-enable strobes, the address and the outgoing data bus for that request. Every setup time, hold time, pulse width and access time is a whole number of system-clock cycles, and each one is set by a parameter.

A byte write is controlled by the write-enable strobe. The device then starts its internal programming cycle, and the sequencer tracks its progress by reading the same address again and again. While the memory is busy it returns the inverse of the written top bit. When bit 7 of a poll matches the written bit 7, the write is complete. If polling outlasts a parameterised limit, the request ends with an error. After reset, no request is accepted until a power-up wait has expired.

Each finished request gives a one-cycle `done` pulse, together with the byte that was read and the error flag.

Top module: `eewr_seq`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly PWRUP_CYC clock cycles and then rises. During reset and this wait, all three strobes are high (inactive), the data bus is not driven and `done` is low.
- R2: The address is held constant for as long as chip enable is low. Write enable goes low only while chip enable is low and output enable is high.
- R3: Before write enable falls, chip enable is low, output enable is high and the data bus is driven for at least max(OES_CYC, AS_CYC) cycles. Write enable then stays low for exactly WP_CYC cycles, with the data driven throughout. Afterwards, chip enable stays low, output enable stays high and the data bus stays driven for at least max(DH_CYC, OEH_CYC) cycles.
- R4: After a write, the sequencer polls the written address. In each poll, chip enable and output enable are low for exactly ACC_CYC cycles and the byte is sampled in the last of those cycles. Between polls, and before the first one, both strobes are high and the bus is released for at least GAP_CYC cycles.
- R5: A write completes at the first poll whose bit 7 equals bit 7 of the written byte. The sequencer then gives one `done` pulse with `timeout_err` = 0 and `rd_data` equal to that polled byte. A poll whose bit 7 is inverted never ends the write successfully.
- R6: A read request holds chip enable and output enable low for exactly ACC_CYC cycles. It then gives a one-cycle `done` pulse with `rd_data` equal to the byte at the requested address.
- R7: If bit 7 still differs at a poll that ends TMO_CYC or more cycles after write enable rose, polling stops. The sequencer then gives a `done` pulse with `timeout_err` = 1 in the same cycle.
- R8: `req_ready` is high only when the sequencer is idle. A request offered while an operation is in progress is not taken: it causes no memory access and writes nothing.
- R9: The data bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken on this cycle if valid |
| req_write | input | 1 | 1 = byte write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte from the last read or completing poll |
| timeout_err | output | 1 | With done: the write did not complete in time |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Host drives the data bus when high |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The assertions assume that `mem_dq_in` is a stable function of the strobes and the address within each clock cycle. They also assume that the host keeps `req_valid` and the request fields steady until they are taken, and that every timing parameter is at least one.

The memory model in the bench answers combinationally from chip enable, output enable and address. It reports the inverted top bit for exactly the busy time it is given. In the bench, requests offered during an operation are withdrawn before the sequencer can be idle, so that test measures only whether anything was taken.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [3:0] {
    ST_PWR,   // power-up wait
    ST_IDLE,  // ready for a request
    ST_WSET,  // write: address/data/OE-high setup
    ST_WPUL,  // write: WE low
    ST_WHLD,  // write: hold after WE rise
    ST_PGAP,  // poll: strobes high, bus released
    ST_PRD,   // poll: CE/OE low, sample at end
    ST_RRD,   // read: CE/OE low, sample at end
    ST_RGAP   // read: recovery before idle
  } eewr_st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eewr_phase_tmr.sv
// Short down-counter timing each bus phase; zero marks the last cycle.
module eewr_phase_tmr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = ld_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/eewr_span_tmr.sv
// Long interval counter; expired once LIMIT cycles have passed since load
// (or since reset when START_AT_RESET is set).
module eewr_span_tmr #(
  parameter int LIMIT          = 1000,
  parameter bit START_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LD_VAL = CW'(LIMIT - 1);
  localparam logic [CW-1:0] RST_VAL = START_AT_RESET ? LD_VAL : '0;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = LD_VAL;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= RST_VAL;
    else
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eewr_seq.sv
module eewr_seq
  import eewr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PWRUP_CYC = 2_500_000, // 20 ms at 125 MHz
  parameter int OES_CYC   = 2,         // OE high before WE falls
  parameter int AS_CYC    = 2,         // address setup before WE falls
  parameter int WP_CYC    = 19,        // WE low width
  parameter int DH_CYC    = 2,         // data hold after WE rises
  parameter int OEH_CYC   = 2,         // OE high after WE rises
  parameter int ACC_CYC   = 26,        // CE/OE low before sampling
  parameter int GAP_CYC   = 2,         // strobes high between reads
  parameter int TMO_CYC   = 1_250_000  // 10 ms write limit
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              timeout_err,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [7:0]        mem_dq_in
);

  localparam int SET_LEN = imax(OES_CYC, AS_CYC);
  localparam int HLD_LEN = imax(DH_CYC, OEH_CYC);
  localparam int PH_MAX  = imax(imax(SET_LEN, HLD_LEN),
                                imax(imax(WP_CYC, ACC_CYC), GAP_CYC));
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int POLL_BIT = 7;

  eewr_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdat_q;
  logic [7:0]        rd_q;
  logic              done_q, err_q;

  logic              accept, cap, finish, finish_err;
  logic              ph_load, ph_zero, tmo_start, tmo_exp, pwr_exp;
  logic [PH_W-1:0]   ph_val;

  // ---------------- timers ----------------
  eewr_phase_tmr #(.W(PH_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ph_load),
    .ld_val (ph_val),
    .zero   (ph_zero)
  );

  eewr_span_tmr #(.LIMIT(PWRUP_CYC), .START_AT_RESET(1'b1)) u_pwrup (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (1'b0),
    .expired (pwr_exp)
  );

  eewr_span_tmr #(.LIMIT(TMO_CYC), .START_AT_RESET(1'b0)) u_wlimit (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmo_start),
    .expired (tmo_exp)
  );

  // ---------------- next state ----------------
  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign tmo_start = (st_q == ST_WPUL) && ph_zero;

  always_comb begin
    st_d       = st_q;
    cap        = 1'b0;
    finish     = 1'b0;
    finish_err = 1'b0;
    unique case (st_q)
      ST_PWR:  if (pwr_exp) st_d = ST_IDLE;
      ST_IDLE: if (req_valid) st_d = req_write ? ST_WSET : ST_RRD;
      ST_WSET: if (ph_zero) st_d = ST_WPUL;
      ST_WPUL: if (ph_zero) st_d = ST_WHLD;
      ST_WHLD: if (ph_zero) st_d = ST_PGAP;
      ST_PGAP: if (ph_zero) st_d = ST_PRD;
      ST_PRD: begin
        if (ph_zero) begin
          cap = 1'b1;
          if (mem_dq_in[POLL_BIT] == wdat_q[POLL_BIT]) begin
            finish = 1'b1;
            st_d   = ST_IDLE;
          end else if (tmo_exp) begin
            finish     = 1'b1;
            finish_err = 1'b1;
            st_d       = ST_IDLE;
          end else begin
            st_d = ST_PGAP;
          end
        end
      end
      ST_RRD: begin
        if (ph_zero) begin
          cap    = 1'b1;
          finish = 1'b1;
          st_d   = ST_RGAP;
        end
      end
      ST_RGAP: if (ph_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // phase length for the state being entered
  assign ph_load = (st_d != st_q);

  always_comb begin
    unique case (st_d)
      ST_WSET:          ph_val = PH_W'(SET_LEN - 1);
      ST_WPUL:          ph_val = PH_W'(WP_CYC - 1);
      ST_WHLD:          ph_val = PH_W'(HLD_LEN - 1);
      ST_PGAP, ST_RGAP: ph_val = PH_W'(GAP_CYC - 1);
      ST_PRD, ST_RRD:   ph_val = PH_W'(ACC_CYC - 1);
      default:          ph_val = '0;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWR;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      err_q  <= finish_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (cap)
      rd_q <= mem_dq_in;
  end

  // ---------------- outputs ----------------
  assign req_ready   = (st_q == ST_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
  assign rd_data     = rd_q;
  assign mem_addr    = addr_q;
  assign mem_dq_out  = wdat_q;
  assign mem_ce_n    = !(st_q inside {ST_WSET, ST_WPUL, ST_WHLD, ST_PRD, ST_RRD});
  assign mem_oe_n    = !(st_q inside {ST_PRD, ST_RRD});
  assign mem_we_n    = (st_q != ST_WPUL);
  assign mem_dq_oe   = (st_q inside {ST_WSET, ST_WPUL, ST_WHLD});

  // ---------------- assertions ----------------
  // R1
  pwr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_exp |-> (!req_ready && mem_ce_n && mem_we_n));

  // R2
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R3
  we_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  // R9
  bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

endmodule

// File: tb/eewr_seq_bench.sv
`timescale 1ns/1ps
module eewr_seq_bench;

  localparam int AW    = 4;
  localparam int PWRUP = 50;
  localparam int OES   = 2;
  localparam int AS    = 3;
  localparam int WP    = 5;
  localparam int DH    = 2;
  localparam int OEH   = 1;
  localparam int ACC   = 4;
  localparam int GAP   = 2;
  localparam int TMO   = 200;
  localparam int SETL  = (OES > AS) ? OES : AS;
  localparam int HLDL  = (DH > OEH) ? DH : OEH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, done, timeout_err;
  logic [7:0] rd_data;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dq_out, mem_dq_in;

  always #4 clk = ~clk; // 125 MHz

  eewr_seq #(
    .ADDR_W(AW), .PWRUP_CYC(PWRUP), .OES_CYC(OES), .AS_CYC(AS), .WP_CYC(WP),
    .DH_CYC(DH), .OEH_CYC(OEH), .ACC_CYC(ACC), .GAP_CYC(GAP), .TMO_CYC(TMO)
  ) u_eewr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .timeout_err(timeout_err),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_run = 0, n_fail = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and monitors ----------------
  logic [7:0] mem [16];
  int   busy = 0, busy_len = 10;
  bit   stuck = 0;
  logic [AW-1:0] baddr;
  logic [7:0] bdat, lat_dat;
  int   cyc = 0, wr_count = 0, we_rise_cyc = 0;
  int   we_run = 0, last_we = 0, set_run = 0, last_set = 0;
  int   hold_run = 0, last_hold = 0, in_hold = 0;
  int   oe_run = 0, last_acc = 0, gap_run = 0, min_gap = 1000, gap_valid = 0;
  int   poll_cnt = 0, viol2 = 0, viol3 = 0, viol9 = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1;
  logic [AW-1:0] prev_addr = '0;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n)
                     ? ((busy != 0 && mem_addr == baddr) ? {~bdat[7], 7'h15} : mem[mem_addr])
                     : 8'hFF;

  initial for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      // model: write latched at WE rise
      if (prev_we == 1'b0 && mem_we_n == 1'b1) begin
        mem[mem_addr] = lat_dat;
        baddr = mem_addr; bdat = lat_dat;
        busy = busy_len; wr_count++;
        we_rise_cyc = cyc;
        last_we = we_run; we_run = 0;
        in_hold = 1; hold_run = 0;
      end else if (busy != 0 && !stuck) begin
        busy = busy - 1;
      end
      if (!mem_we_n) begin
        lat_dat = mem_dq_out; we_run++;
        if (!mem_dq_oe) viol3++;
      end
      // setup run before WE fall
      if (!mem_ce_n && mem_oe_n && mem_we_n && mem_dq_oe && !in_hold) set_run++;
      if (prev_we == 1'b1 && mem_we_n == 1'b0) begin last_set = set_run; set_run = 0; end
      if (mem_ce_n) set_run = 0;
      // hold after WE rise
      if (in_hold == 1 && mem_we_n) begin
        if (!mem_ce_n && mem_oe_n && mem_dq_oe) hold_run++;
        else begin last_hold = hold_run; in_hold = 0; end
      end
      // read access and gap
      if (!mem_oe_n) oe_run++;
      if (prev_oe == 1'b0 && mem_oe_n) begin last_acc = oe_run; oe_run = 0; gap_run = 0; gap_valid = 1; end
      if (mem_oe_n && mem_ce_n && !mem_dq_oe) gap_run++;
      if (prev_oe == 1'b1 && !mem_oe_n) begin
        poll_cnt++;
        if (gap_valid && gap_run < min_gap) min_gap = gap_run;
      end
      if (!mem_oe_n && mem_dq_oe) viol9++;
      if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) viol2++;
    end
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n; prev_addr = mem_addr;
  end

  // ---------------- helpers ----------------
  task automatic tick(); @(negedge clk); #1; endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
    tick();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int at);
    while (!done) tick();
    at = cyc;
  endtask

  task automatic clear_mon();
    poll_cnt = 0; min_gap = 1000; gap_valid = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    tick(); tick();
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !done && !req_ready, "R1", "bus/done/ready in reset",
        {mem_dq_oe, done, req_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!req_ready && n < 1000);
    chk(n == PWRUP, "R1", "cycles until ready", n, PWRUP);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [7:0] d, input int blen);
    int at;
    busy_len = blen; clear_mon();
    issue(1'b1, a, d);
    wait_done(at);
    chk(timeout_err == 1'b0, "R5", "no timeout", timeout_err, 0);
    chk(rd_data == d, "R5", "polled byte", rd_data, d);
    chk(mem[a] == d, "R3", "byte stored", mem[a], d);
    chk(at - we_rise_cyc >= blen, "R5", "not before busy ends", at - we_rise_cyc, blen);
    chk(last_we == WP, "R3", "WE low width", last_we, WP);
    chk(last_set >= SETL, "R3", "setup before WE", last_set, SETL);
    chk(last_hold >= HLDL, "R3", "hold after WE", last_hold, HLDL);
    chk(last_acc == ACC, "R4", "poll access length", last_acc, ACC);
    chk(min_gap >= GAP, "R4", "gap between polls", min_gap, GAP);
    if (blen > 3 * (GAP + ACC))
      chk(poll_cnt >= 2, "R4", "repeated polls", poll_cnt, 2);
    chk(viol2 == 0, "R2", "addr steady under CE", viol2, 0);
    chk(viol3 == 0, "R3", "data during WE", viol3, 0);
    chk(viol9 == 0, "R9", "no drive with OE low", viol9, 0);
    tick();
    chk(done == 1'b0, "R6", "done single pulse", done, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    int at;
    logic [7:0] exp;
    exp = mem[a];
    issue(1'b0, a, 8'h00);
    wait_done(at);
    chk(rd_data == exp, "R6", "read byte", rd_data, exp);
    chk(last_acc == ACC, "R6", "read access length", last_acc, ACC);
    tick();
    chk(done == 1'b0, "R6", "read done single pulse", done, 0);
  endtask

  task automatic t_busy_reject();
    int at, seen_ready, wc0;
    logic [7:0] other;
    other = mem[9];
    wc0 = wr_count;
    busy_len = 60;
    issue(1'b1, 4'd2, 8'h5A);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd9; req_wdata = 8'hC3;
    seen_ready = 0;
    for (int i = 0; i < 30; i++) begin
      if (req_ready) seen_ready++;
      tick();
    end
    req_valid = 1'b0;
    wait_done(at);
    chk(seen_ready == 0, "R8", "ready while busy", seen_ready, 0);
    chk(wr_count - wc0 == 1, "R8", "writes performed", wr_count - wc0, 1);
    tick(); tick();
    t_read(4'd9);
    chk(rd_data == other, "R8", "other address untouched", rd_data, other);
  endtask

  task automatic t_timeout();
    int at;
    stuck = 1; busy_len = 5;
    issue(1'b1, 4'd7, 8'h81);
    wait_done(at);
    chk(timeout_err == 1'b1, "R7", "timeout flagged", timeout_err, 1);
    chk(at - we_rise_cyc >= TMO, "R7", "not before limit", at - we_rise_cyc, TMO);
    chk(at - we_rise_cyc <= TMO + 2 * (GAP + ACC) + HLDL + 2, "R7", "stops soon after limit",
        at - we_rise_cyc, TMO);
    chk(rd_data[7] == 1'b0, "R7", "last poll inverted", rd_data[7], 0);
    stuck = 0; busy = 0;
    tick();
    chk(timeout_err == 1'b0 && done == 1'b0, "R7", "error pulse ends", timeout_err, 0);
  endtask

  // ---------------- main ----------------
  initial begin
    t_reset();
    t_write(4'd3, 8'hA5, 40);  // bit 7 set
    t_write(4'd4, 8'h3C, 40);  // bit 7 clear
    t_write(4'd5, 8'h80, 1);   // completes on first poll
    t_read(4'd3);
    t_read(4'd11);
    t_busy_reject();
    t_timeout();
    t_write(4'd6, 8'h7F, 25);  // recovers after timeout
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 100000 && !ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule